// File: doc/BRIEF.md
# Circular Buffer DMA Write-Pointer Controller

This block steers one stream of DMA writes around a ring-shaped region of memory. Software supplies four offsets relative to the buffer base: where the ring starts, where it ends, a limit, and an interrupt threshold. The block watches how much stream data is buffered upstream. Whenever a full 128-byte burst is waiting, it asks the bus master to write that burst at the current pointer. It moves the pointer forward only once the memory has confirmed the burst. Software can therefore trust every byte below the pointer. When the pointer reaches the end offset it jumps back to the start offset. When it sits on the limit, bursts stop until software moves the limit on.

An interrupt threshold lets software sleep until the stream has made a chosen amount of progress. A pending flag latches when a completed burst carries the pointer across the threshold. The flag holds until software clears it. A master enable gates the flag onto the interrupt line.

The controller is a five-state machine. IDLE waits for a burst to become possible. ISSUE raises the request for one cycle. WAIT holds until the burst completes or fails. DRAIN waits for a burst that was orphaned by a re-initialisation. FAULT parks after a failed burst. The transitions are:
- IDLE→ISSUE when the stream is enabled, a full burst is buffered and the pointer is not at the limit.
- ISSUE→WAIT, or ISSUE→DRAIN if an init arrives in the same cycle.
- WAIT→IDLE on completion, which advances the pointer.
- WAIT→DRAIN on init.
- WAIT→FAULT on error.
- DRAIN→IDLE on completion, without advancing.
- DRAIN→FAULT on error.
- FAULT→IDLE on an error clear.

Top module: `dma_ring_wptr`

## Requirements
- R1: After reset, `wr_ptr` is 0 and `burst_req`, `busy`, `irq_pending`, `irq_out` and `buf_flush` are all 0.
- R2: `burst_req` is a one-cycle pulse. It rises in the cycle after the machine, while idle, sees all of the following: `stream_en`=1, `fifo_words` of at least 16 (the count is in 8-byte words, so 16 words is 128 bytes), and a pointer different from the limit. `burst_addr` then equals `wr_ptr`. With 15 or fewer words buffered, no request is made.
- R3: `wr_ptr` does not change when a burst is requested. It advances by 128 bytes on the clock edge that samples `burst_done` while the burst is outstanding.
- R4: When the advanced pointer equals the end offset (`cfg_end_blk`×128), `wr_ptr` becomes the start offset (`cfg_start_blk`×128) on that same edge.
- R5: While `wr_ptr` equals `cfg_limit_blk`×128, no burst is requested. Once software changes the limit, requests resume.
- R6: `irq_pending` is set on a completion edge when `irq_en`=1 and the threshold lies in the range old pointer < `cfg_thresh_wrd`×8 ≤ old pointer+128. The flag is not set when `irq_en`=0. It stays set until `irq_clear` is sampled, and a clear overrides a set arriving in the same cycle.
- R7: `irq_out` is 1 exactly when `irq_pending`=1 and `master_irq_en`=1.
- R8: `stream_init` loads `wr_ptr` with the start offset on the next edge and pulses `buf_flush` for one cycle. If a burst is outstanding at that time, its later completion does not advance the pointer.
- R9: Dropping `stream_en` while a burst is outstanding lets that burst complete and advance the pointer. No further request follows.
- R10: `busy` is 1 from the request cycle until the edge that samples the burst's completion or error.
- R11: A sampled `burst_error` leaves `wr_ptr` unchanged and clears `busy`. No request is made until `error_clear` is sampled, after which requests resume at the same pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_blk | input | ADDR_W-BURST_LSB | Ring start offset in 128-byte units |
| cfg_end_blk | input | ADDR_W-BURST_LSB | Ring end offset (exclusive) in 128-byte units |
| cfg_limit_blk | input | ADDR_W-BURST_LSB | Pause offset in 128-byte units |
| cfg_thresh_wrd | input | ADDR_W-WORD_LSB | Interrupt threshold in 8-byte units |
| stream_en | input | 1 | Allow new bursts |
| stream_init | input | 1 | Restart pointer at start, flush buffered data |
| irq_en | input | 1 | Stream interrupt enable |
| irq_clear | input | 1 | Clear the pending flag |
| master_irq_en | input | 1 | Global interrupt gate |
| fifo_words | input | LVL_W | Buffered 8-byte words ready to send |
| burst_done | input | 1 | Outstanding burst completed |
| burst_error | input | 1 | Outstanding burst failed |
| error_clear | input | 1 | Leave the fault state |
| burst_req | output | 1 | One-cycle burst request |
| burst_addr | output | ADDR_W | Offset of the requested burst |
| wr_ptr | output | ADDR_W | Offset where the next write begins |
| busy | output | 1 | A burst is outstanding |
| irq_pending | output | 1 | Sticky threshold flag |
| irq_out | output | 1 | Gated interrupt line |
| buf_flush | output | 1 | One-cycle discard pulse to the data buffer |

## Verification
A wrong state shows up at the ports within one or two cycles. If the machine is stuck in WAIT or DRAIN, `busy` stays high after completion and no second request arrives. If it leaks out of FAULT, a request appears before `error_clear`. A wrong pointer update shows up in `wr_ptr` on the completion edge itself: an early advance at request time, a missed wrap, or an advance after an orphaned burst. A wrong threshold window or a lost sticky bit shows in `irq_pending` on the edge after the crossing burst, or on any later cycle before the clear.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_FAULT = 3'd4
    } ring_state_t;

endpackage

// File: rtl/ring_burst_fsm.sv
module ring_burst_fsm
    import ring_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int WORDS_PER_BURST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stream_en,
    input  logic             stream_init,
    input  logic [LVL_W-1:0] fifo_words,
    input  logic             at_limit,
    input  logic             burst_done,
    input  logic             burst_error,
    input  logic             error_clear,
    output logic             burst_req,
    output logic             busy,
    output logic             issue_go,
    output logic             advance,
    output logic             flush
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(WORDS_PER_BURST);

    ring_state_t state_q, state_d;
    logic        can_issue;

    assign can_issue = stream_en && (fifo_words >= FULL_LVL) && !at_limit && !stream_init;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flush   <= 1'b0;
        end else begin
            state_q <= state_d;
            flush   <= stream_init;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (can_issue) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_d = stream_init ? ST_DRAIN : ST_WAIT;
            end
            ST_WAIT: begin
                if (burst_error)      state_d = ST_FAULT;
                else if (burst_done)  state_d = ST_IDLE;
                else if (stream_init) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (burst_error)     state_d = ST_FAULT;
                else if (burst_done) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (error_clear) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        burst_req = 1'b0;
        busy      = 1'b0;
        issue_go  = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                issue_go = can_issue;
            end
            ST_ISSUE: begin
                burst_req = 1'b1;
                busy      = 1'b1;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                advance = burst_done && !burst_error && !stream_init;
            end
            ST_DRAIN: begin
                busy = 1'b1;
            end
            ST_FAULT: begin
                busy = 1'b0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit #(
    parameter int BLK_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] start_blk,
    input  logic [BLK_W-1:0] end_blk,
    input  logic [BLK_W-1:0] limit_blk,
    input  logic             init,
    input  logic             advance,
    input  logic             issue_go,
    output logic [BLK_W-1:0] ptr_blk,
    output logic [BLK_W-1:0] req_blk,
    output logic             at_limit
);

    logic [BLK_W-1:0] step_blk;
    logic [BLK_W-1:0] wrap_blk;

    assign step_blk = ptr_blk + BLK_W'(1);
    assign wrap_blk = (step_blk == end_blk) ? start_blk : step_blk;
    assign at_limit = (ptr_blk == limit_blk);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_blk <= '0;
            req_blk <= '0;
        end else begin
            if (init)         ptr_blk <= start_blk;
            else if (advance) ptr_blk <= wrap_blk;
            if (issue_go)     req_blk <= ptr_blk;
        end
    end

endmodule

// File: rtl/ring_irq_unit.sv
module ring_irq_unit #(
    parameter int BLK_W = 25,
    parameter int SUB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BLK_W-1:0]       ptr_blk,
    input  logic [BLK_W+SUB_W-1:0] thresh_wrd,
    input  logic                   advance,
    input  logic                   irq_en,
    input  logic                   irq_clear,
    input  logic                   master_en,
    output logic                   pending,
    output logic                   irq_out
);

    localparam int WRD_W = BLK_W + SUB_W;

    logic [WRD_W-1:0] old_wrd;
    logic [WRD_W:0]   new_wrd;
    logic             crossed;

    assign old_wrd = {ptr_blk, {SUB_W{1'b0}}};
    assign new_wrd = {1'b0, old_wrd} + (WRD_W+1)'(1 << SUB_W);
    assign crossed = (thresh_wrd > old_wrd) && ({1'b0, thresh_wrd} <= new_wrd);

    always_ff @(posedge clk) begin
        if (!rst_n)                          pending <= 1'b0;
        else if (irq_clear)                  pending <= 1'b0;
        else if (advance && irq_en && crossed) pending <= 1'b1;
    end

    assign irq_out = pending & master_en;

endmodule

// File: rtl/dma_ring_wptr.sv
module dma_ring_wptr #(
    parameter int ADDR_W    = 32,
    parameter int BURST_LSB = 7,
    parameter int WORD_LSB  = 3,
    parameter int LVL_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-BURST_LSB-1:0] cfg_start_blk,
    input  logic [ADDR_W-BURST_LSB-1:0] cfg_end_blk,
    input  logic [ADDR_W-BURST_LSB-1:0] cfg_limit_blk,
    input  logic [ADDR_W-WORD_LSB-1:0]  cfg_thresh_wrd,
    input  logic                        stream_en,
    input  logic                        stream_init,
    input  logic                        irq_en,
    input  logic                        irq_clear,
    input  logic                        master_irq_en,
    input  logic [LVL_W-1:0]            fifo_words,
    input  logic                        burst_done,
    input  logic                        burst_error,
    input  logic                        error_clear,
    output logic                        burst_req,
    output logic [ADDR_W-1:0]           burst_addr,
    output logic [ADDR_W-1:0]           wr_ptr,
    output logic                        busy,
    output logic                        irq_pending,
    output logic                        irq_out,
    output logic                        buf_flush
);

    localparam int BLK_W = ADDR_W - BURST_LSB;
    localparam int SUB_W = BURST_LSB - WORD_LSB;
    localparam int WORDS_PER_BURST = 1 << SUB_W;

    logic [BLK_W-1:0] ptr_blk;
    logic [BLK_W-1:0] req_blk;
    logic             at_limit;
    logic             issue_go;
    logic             advance;

    ring_burst_fsm #(
        .LVL_W          (LVL_W),
        .WORDS_PER_BURST(WORDS_PER_BURST)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_en  (stream_en),
        .stream_init(stream_init),
        .fifo_words (fifo_words),
        .at_limit   (at_limit),
        .burst_done (burst_done),
        .burst_error(burst_error),
        .error_clear(error_clear),
        .burst_req  (burst_req),
        .busy       (busy),
        .issue_go   (issue_go),
        .advance    (advance),
        .flush      (buf_flush)
    );

    ring_ptr_unit #(
        .BLK_W(BLK_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_blk(cfg_start_blk),
        .end_blk  (cfg_end_blk),
        .limit_blk(cfg_limit_blk),
        .init     (stream_init),
        .advance  (advance),
        .issue_go (issue_go),
        .ptr_blk  (ptr_blk),
        .req_blk  (req_blk),
        .at_limit (at_limit)
    );

    ring_irq_unit #(
        .BLK_W(BLK_W),
        .SUB_W(SUB_W)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_blk   (ptr_blk),
        .thresh_wrd(cfg_thresh_wrd),
        .advance   (advance),
        .irq_en    (irq_en),
        .irq_clear (irq_clear),
        .master_en (master_irq_en),
        .pending   (irq_pending),
        .irq_out   (irq_out)
    );

    assign wr_ptr     = {ptr_blk, {BURST_LSB{1'b0}}};
    assign burst_addr = {req_blk, {BURST_LSB{1'b0}}};

endmodule

// File: rtl/ring_wptr_checker.sv
module ring_wptr_checker #(
    parameter int ADDR_W    = 32,
    parameter int BURST_LSB = 7,
    parameter int WORD_LSB  = 3,
    parameter int LVL_W     = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        stream_en,
    input logic                        stream_init,
    input logic [LVL_W-1:0]            fifo_words,
    input logic [ADDR_W-BURST_LSB-1:0] cfg_limit_blk,
    input logic                        burst_done,
    input logic                        burst_req,
    input logic                        busy,
    input logic [ADDR_W-1:0]           wr_ptr,
    input logic                        irq_pending,
    input logic                        irq_clear
);

    localparam int WPB = 1 << (BURST_LSB - WORD_LSB);

    p_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> ($past(stream_en) && ($past(fifo_words) >= LVL_W'(WPB))
                       && ($past(wr_ptr) != {$past(cfg_limit_blk), {BURST_LSB{1'b0}}})));

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |=> !burst_req);

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_done && !stream_init) |=> $stable(wr_ptr));

    p_busy_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |=> busy);

    p_pending_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_clear) |=> irq_pending);

    p_pending_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> !irq_pending);

endmodule

bind dma_ring_wptr ring_wptr_checker #(
    .ADDR_W   (ADDR_W),
    .BURST_LSB(BURST_LSB),
    .WORD_LSB (WORD_LSB),
    .LVL_W    (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stream_en    (stream_en),
    .stream_init  (stream_init),
    .fifo_words   (fifo_words),
    .cfg_limit_blk(cfg_limit_blk),
    .burst_done   (burst_done),
    .burst_req    (burst_req),
    .busy         (busy),
    .wr_ptr       (wr_ptr),
    .irq_pending  (irq_pending),
    .irq_clear    (irq_clear)
);

// File: tb/tb_dma_ring_wptr.sv
`timescale 1ns/1ps
module tb_dma_ring_wptr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] cfg_start_blk = 25'd4;
    logic [24:0] cfg_end_blk = 25'd8;
    logic [24:0] cfg_limit_blk = 25'd0;
    logic [28:0] cfg_thresh_wrd = 29'd0;
    logic        stream_en = 1'b0;
    logic        stream_init = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq_clear = 1'b0;
    logic        master_irq_en = 1'b0;
    logic [7:0]  fifo_words = 8'd0;
    logic        burst_done = 1'b0;
    logic        burst_error = 1'b0;
    logic        error_clear = 1'b0;
    logic        burst_req;
    logic [31:0] burst_addr;
    logic [31:0] wr_ptr;
    logic        busy;
    logic        irq_pending;
    logic        irq_out;
    logic        buf_flush;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dma_ring_wptr dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_blk(cfg_start_blk), .cfg_end_blk(cfg_end_blk),
        .cfg_limit_blk(cfg_limit_blk), .cfg_thresh_wrd(cfg_thresh_wrd),
        .stream_en(stream_en), .stream_init(stream_init),
        .irq_en(irq_en), .irq_clear(irq_clear), .master_irq_en(master_irq_en),
        .fifo_words(fifo_words), .burst_done(burst_done),
        .burst_error(burst_error), .error_clear(error_clear),
        .burst_req(burst_req), .burst_addr(burst_addr), .wr_ptr(wr_ptr),
        .busy(busy), .irq_pending(irq_pending), .irq_out(irq_out),
        .buf_flush(buf_flush)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input string tag, input logic [31:0] exp_addr);
        bit got = 0;
        fifo_words = 8'd16;
        for (int i = 0; i < 8 && !got; i++) begin
            step(1);
            if (burst_req) got = 1;
        end
        check({tag, " request seen"}, 32'(got), 32'd1);
        check({tag, " burst_addr"}, burst_addr, exp_addr);
    endtask

    task automatic count_reqs(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (burst_req) seen++;
        end
    endtask

    task automatic finish_burst(input string tag, input logic [31:0] exp_ptr);
        step(1);
        burst_done = 1'b1;
        fifo_words = 8'd0;
        step(1);
        burst_done = 1'b0;
        check({tag, " pointer after completion"}, wr_ptr, exp_ptr);
        check({tag, " busy low after completion"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset;
        step(1);
        check("R1 wr_ptr", wr_ptr, 32'h0);
        check("R1 req/busy/irq/flush", {28'd0, burst_req, busy, irq_pending, buf_flush}, 32'h0);
        check("R1 irq_out", 32'(irq_out), 32'd0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_basic;
        int seen;
        stream_init = 1'b1;
        step(1);
        stream_init = 1'b0;
        check("R8 init loads start", wr_ptr, 32'h200);
        check("R8 flush pulse", 32'(buf_flush), 32'd1);
        step(1);
        check("R8 flush one cycle", 32'(buf_flush), 32'd0);
        stream_en = 1'b1;
        fifo_words = 8'd15;
        count_reqs(6, seen);
        check("R2 no request below 16 words", 32'(seen), 32'd0);
        wait_req("R2 first", 32'h200);
        check("R10 busy in request cycle", 32'(busy), 32'd1);
        check("R3 pointer unchanged at request", wr_ptr, 32'h200);
        step(1);
        check("R2 request lasts one cycle", 32'(burst_req), 32'd0);
        check("R10 busy while outstanding", 32'(busy), 32'd1);
        step(1);
        burst_done = 1'b1;
        fifo_words = 8'd0;
        step(1);
        burst_done = 1'b0;
        check("R3 advance by 128", wr_ptr, 32'h280);
        check("R10 busy cleared", 32'(busy), 32'd0);
    endtask

    task automatic t_wrap;
        wait_req("R4 a", 32'h280);
        finish_burst("R4 a", 32'h300);
        wait_req("R4 b", 32'h300);
        finish_burst("R4 b", 32'h380);
        wait_req("R4 c", 32'h380);
        finish_burst("R4 wrap to start", 32'h200);
    endtask

    task automatic t_limit;
        int seen;
        cfg_limit_blk = 25'd5;
        wait_req("R5 pre", 32'h200);
        finish_burst("R5 pre", 32'h280);
        fifo_words = 8'd16;
        count_reqs(8, seen);
        check("R5 stalled at limit", 32'(seen), 32'd0);
        cfg_limit_blk = 25'd7;
        wait_req("R5 resume after limit moved", 32'h280);
        finish_burst("R5 resume", 32'h300);
        cfg_limit_blk = 25'd0;
    endtask

    task automatic t_irq;
        cfg_thresh_wrd = 29'h68;
        irq_en = 1'b1;
        master_irq_en = 1'b0;
        wait_req("R6 cross", 32'h300);
        finish_burst("R6 cross", 32'h380);
        check("R6 pending on crossing", 32'(irq_pending), 32'd1);
        check("R7 gated off by master", 32'(irq_out), 32'd0);
        master_irq_en = 1'b1;
        step(1);
        check("R7 line with master on", 32'(irq_out), 32'd1);
        step(4);
        check("R6 pending sticky", 32'(irq_pending), 32'd1);
        irq_clear = 1'b1;
        step(1);
        irq_clear = 1'b0;
        check("R6 cleared", 32'(irq_pending), 32'd0);
        check("R7 line falls", 32'(irq_out), 32'd0);
        irq_en = 1'b0;
        cfg_thresh_wrd = 29'h78;
        wait_req("R6 disabled", 32'h380);
        finish_burst("R6 disabled", 32'h200);
        check("R6 no set when stream irq disabled", 32'(irq_pending), 32'd0);
    endtask

    task automatic t_init_mid;
        wait_req("R8 pre", 32'h200);
        finish_burst("R8 pre", 32'h280);
        wait_req("R8 orphan", 32'h280);
        step(1);
        stream_init = 1'b1;
        step(1);
        stream_init = 1'b0;
        check("R8 init mid burst loads start", wr_ptr, 32'h200);
        check("R10 busy while orphan outstanding", 32'(busy), 32'd1);
        burst_done = 1'b1;
        fifo_words = 8'd0;
        step(1);
        burst_done = 1'b0;
        check("R8 orphan completion no advance", wr_ptr, 32'h200);
        check("R10 busy clear after orphan", 32'(busy), 32'd0);
    endtask

    task automatic t_disable;
        int seen;
        wait_req("R9 outstanding", 32'h200);
        stream_en = 1'b0;
        step(1);
        burst_done = 1'b1;
        step(1);
        burst_done = 1'b0;
        check("R9 outstanding burst still advances", wr_ptr, 32'h280);
        fifo_words = 8'd16;
        count_reqs(8, seen);
        check("R9 no request when disabled", 32'(seen), 32'd0);
        fifo_words = 8'd0;
        stream_en = 1'b1;
    endtask

    task automatic t_error;
        int seen;
        wait_req("R11 pre", 32'h280);
        step(1);
        burst_error = 1'b1;
        step(1);
        burst_error = 1'b0;
        check("R11 no advance on error", wr_ptr, 32'h280);
        check("R11 busy clear on error", 32'(busy), 32'd0);
        count_reqs(8, seen);
        check("R11 no request while faulted", 32'(seen), 32'd0);
        error_clear = 1'b1;
        step(1);
        error_clear = 1'b0;
        wait_req("R11 resume after clear", 32'h280);
        finish_burst("R11 resume", 32'h300);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_wrap;
        t_limit;
        t_irq;
        t_init_mid;
        t_disable;
        t_error;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1600000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule